// File: doc/BRIEF.md
# Snooping Write-Back Cache Coherence Controller

This block manages the coherence state of a small direct-mapped cache whose lines each hold a single word. The cache sits on a shared atomic bus with other caches and uses write-back and invalidation on write. Every line is in one of three states: Invalid (no data), Shared (clean and readable) or Exclusive (the only copy, writable and dirty). Processor reads and writes that hit complete locally. Misses become bus transactions. A write to a Shared line counts as a miss. A dirty victim is written back before its replacement is requested.

On the snoop side, the controller watches the transactions that other caches place on the bus. A foreign write miss to a block it holds invalidates the copy. A foreign read miss to a block it holds dirty causes it to supply the data, cancel the memory access and keep a Shared copy. The controller never changes the state of its target line before it owns the bus. It recomputes its request every cycle, so a snoop that arrives during the wait turns the request into whatever miss the line now needs.

Top module: `snoop_msi_cache`

## Requirements
- R1: After reset every line is Invalid, so a request to any index is a miss that raises `bus_req` and does not complete.
- R2: A read to a line that does not hold the address raises `bus_req`. In the granted cycle the controller drives `bus_cmd` = 1 (read miss) with `bus_addr` = {tag, index}, where the index is the low `IDX_W` address bits. In that same cycle it completes the request with `cpu_rdata` = `bus_rdata`. The line then becomes Shared and holds that word.
- R3: A write to an Invalid line issues `bus_cmd` = 2 (write miss) when granted and completes in that cycle. The line then becomes Exclusive and holds the write data.
- R4: A write to a Shared line with a matching tag does not complete locally. It is issued as a write miss (code 2) and leaves the line Exclusive with the new data.
- R5: A miss whose index holds an Exclusive line with a different tag first issues `bus_cmd` = 3 (write back). This carries the victim's address and data on `bus_addr` and `bus_wdata`, makes the line Invalid and does not complete the request. The controller then issues the miss.
- R6: A foreign write miss that matches a valid line makes the line Invalid. If the line was Exclusive, `snp_abort` is raised and `snp_wdata` carries the line's data in that same cycle.
- R7: A foreign read miss that matches an Exclusive line raises `snp_abort`, drives the line's data on `snp_wdata` and leaves the line Shared. A foreign read miss that matches a Shared line raises no abort and leaves the line unchanged.
- R8: A read hit in Shared or Exclusive, and a write hit in Exclusive, complete in the cycle the request is presented and do not raise `bus_req`. A read hit returns the stored word, and a write hit replaces it.
- R9: While waiting for `bus_gnt`, the target line does not change except through a snoop. If a snoop invalidates a Shared target, the pending write is still issued as a write miss. If a snoop cleans the dirty victim, no write-back is issued.
- R10: A snooped transaction is ignored in four cases: its source equals `MY_ID`, its command is write back (3), its tag differs from the line's tag, or the line is Invalid. In each case there is no abort and no state change.
- R11: A snoop that matches the line indexed by a pending hit takes priority. The hit is held back for that cycle and completes once the snoop is gone.
- R12: `bus_cmd` is 0 whenever the controller is not granted, and `bus_src` always carries `MY_ID`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor request, held until `cpu_done` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Request word address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_done | output | 1 | Request completes this cycle |
| cpu_rdata | output | DATA_W | Read data, valid with `cpu_done` |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant for this cycle |
| bus_cmd | output | 2 | Issued command: 0 none, 1 read miss, 2 write miss, 3 write back |
| bus_addr | output | ADDR_W | Issued address |
| bus_wdata | output | DATA_W | Write-back data |
| bus_src | output | ID_W | Requester identity |
| bus_rdata | input | DATA_W | Fill data returned in the granted miss cycle |
| snp_cmd | input | 2 | Observed bus command |
| snp_addr | input | ADDR_W | Observed bus address |
| snp_src | input | ID_W | Observed requester identity |
| snp_abort | output | 1 | Memory access cancelled, this cache supplies the data |
| snp_wdata | output | DATA_W | Supplied dirty data |

## Verification
Hits and snoop responses are combinational. `cpu_done`, `cpu_rdata`, `snp_abort` and `snp_wdata` are therefore due in the cycle their stimulus is applied. A miss completes in the exact cycle that `bus_gnt` is driven, after zero to three idle cycles. Every new line state becomes visible one edge later. The bench drives inputs just after the falling edge and samples one time unit later, within the same cycle. It updates its own model of line states only after the following rising edge. It then confirms each state through the next access's expected hit or miss and bus command. This keeps every comparison in the cycle where the result is due.

// File: rtl/coh_pkg.sv
package coh_pkg;

    typedef enum logic [1:0] {
        LS_INV = 2'd0,
        LS_SHR = 2'd1,
        LS_EXC = 2'd2
    } line_state_e;

    typedef enum logic [1:0] {
        BC_NONE   = 2'd0,
        BC_RDMISS = 2'd1,
        BC_WRMISS = 2'd2,
        BC_WB     = 2'd3
    } bus_cmd_e;

    typedef struct packed {
        logic        hit;
        logic        supply;
        logic        upd;
        line_state_e nxt;
    } snoop_act_t;

    function automatic logic is_miss(input bus_cmd_e c);
        return (c == BC_RDMISS) || (c == BC_WRMISS);
    endfunction

endpackage

// File: rtl/coh_line_array.sv
module coh_line_array
    import coh_pkg::*;
#(
    parameter int IDX_W  = 2,
    parameter int TAG_W  = 4,
    parameter int DATA_W = 8,
    localparam int LINES = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              s_we,
    input  logic [IDX_W-1:0]  s_idx,
    input  line_state_e       s_state,
    input  logic              c_we,
    input  logic [IDX_W-1:0]  c_idx,
    input  line_state_e       c_state,
    input  logic [TAG_W-1:0]  c_tag,
    input  logic [DATA_W-1:0] c_data,
    output line_state_e       st_o   [LINES],
    output logic [TAG_W-1:0]  tag_o  [LINES],
    output logic [DATA_W-1:0] data_o [LINES]
);

    for (genvar i = 0; i < LINES; i++) begin : g_line
        line_state_e       st_q;
        logic [TAG_W-1:0]  tag_q;
        logic [DATA_W-1:0] data_q;

        // snoop update wins; the request side never writes a line a snoop touches
        always_ff @(posedge clk) begin
            if (rst) begin
                st_q   <= LS_INV;
                tag_q  <= '0;
                data_q <= '0;
            end else if (s_we && s_idx == IDX_W'(i)) begin
                st_q <= s_state;
            end else if (c_we && c_idx == IDX_W'(i)) begin
                st_q   <= c_state;
                tag_q  <= c_tag;
                data_q <= c_data;
            end
        end

        assign st_o[i]   = st_q;
        assign tag_o[i]  = tag_q;
        assign data_o[i] = data_q;
    end

endmodule

// File: rtl/coh_snoop_unit.sv
module coh_snoop_unit
    import coh_pkg::*;
#(
    parameter int TAG_W  = 4,
    parameter int DATA_W = 8,
    parameter int ID_W   = 2,
    parameter logic [ID_W-1:0] MY_ID = '0
) (
    input  bus_cmd_e          cmd,
    input  logic [ID_W-1:0]   src,
    input  logic [TAG_W-1:0]  tag,
    input  line_state_e       lst,
    input  logic [TAG_W-1:0]  ltag,
    input  logic [DATA_W-1:0] ldata,
    output snoop_act_t        act,
    output logic [DATA_W-1:0] sdata
);

    logic hit;
    logic dirty;

    always_comb begin
        hit        = is_miss(cmd) && (src != MY_ID) && (lst != LS_INV) && (ltag == tag);
        dirty      = hit && (lst == LS_EXC);
        act.hit    = hit;
        act.supply = dirty;
        act.upd    = hit && ((cmd == BC_WRMISS) || dirty);
        act.nxt    = (cmd == BC_WRMISS) ? LS_INV : LS_SHR;
        sdata      = dirty ? ldata : '0;
    end

endmodule

// File: rtl/coh_req_unit.sv
module coh_req_unit
    import coh_pkg::*;
#(
    parameter int TAG_W  = 4,
    parameter int DATA_W = 8
) (
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [TAG_W-1:0]  ctag,
    input  logic [DATA_W-1:0] cwdata,
    input  line_state_e       lst,
    input  logic [TAG_W-1:0]  ltag,
    input  logic [DATA_W-1:0] ldata,
    input  logic              bus_gnt,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              snp_block,
    output logic              cpu_done,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              bus_req,
    output bus_cmd_e          bus_cmd,
    output logic [TAG_W-1:0]  bus_tag,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              c_we,
    output line_state_e       c_state,
    output logic [DATA_W-1:0] c_data
);

    logic tag_eq, hit, local_done, need_wb, gnt_ok, fill;

    // the request is re-derived each cycle from the live line, so a snoop
    // during the grant wait changes the issued command automatically
    always_comb begin
        tag_eq     = (lst != LS_INV) && (ltag == ctag);
        hit        = cpu_req && tag_eq && (!cpu_we || lst == LS_EXC);
        local_done = hit && !snp_block;
        need_wb    = (lst == LS_EXC) && !tag_eq;
        bus_req    = cpu_req && !hit;
        gnt_ok     = bus_req && bus_gnt;
        fill       = gnt_ok && !need_wb;

        if (!gnt_ok)      bus_cmd = BC_NONE;
        else if (need_wb) bus_cmd = BC_WB;
        else if (cpu_we)  bus_cmd = BC_WRMISS;
        else              bus_cmd = BC_RDMISS;

        bus_tag   = need_wb ? ltag : ctag;
        bus_wdata = (gnt_ok && need_wb) ? ldata : '0;

        cpu_done  = local_done || fill;
        if (fill)            cpu_rdata = bus_rdata;
        else if (local_done) cpu_rdata = ldata;
        else                 cpu_rdata = '0;

        c_we = (local_done && cpu_we) || gnt_ok;
        if (gnt_ok && need_wb) c_state = LS_INV;
        else if (cpu_we)       c_state = LS_EXC;
        else                   c_state = LS_SHR;
        if (cpu_we)    c_data = cwdata;
        else if (fill) c_data = bus_rdata;
        else           c_data = ldata;
    end

endmodule

// File: rtl/snoop_msi_cache.sv
module snoop_msi_cache
    import coh_pkg::*;
#(
    parameter int IDX_W  = 2,
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8,
    parameter int ID_W   = 2,
    parameter logic [ID_W-1:0] MY_ID = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_done,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic [1:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic [ID_W-1:0]   bus_src,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic [1:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic [ID_W-1:0]   snp_src,
    output logic              snp_abort,
    output logic [DATA_W-1:0] snp_wdata
);

    localparam int LINES = 1 << IDX_W;
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [IDX_W-1:0]  c_idx, s_idx;
    logic [TAG_W-1:0]  c_tag_in, s_tag_in, bus_tag;
    line_state_e       st_a   [LINES];
    logic [TAG_W-1:0]  tag_a  [LINES];
    logic [DATA_W-1:0] data_a [LINES];
    snoop_act_t        sact;
    logic              snp_block, c_we;
    line_state_e       c_state;
    logic [DATA_W-1:0] c_data;
    bus_cmd_e          cmd_out;
    bus_cmd_e          snp_cmd_e;

    assign c_idx     = cpu_addr[IDX_W-1:0];
    assign c_tag_in  = cpu_addr[ADDR_W-1:IDX_W];
    assign s_idx     = snp_addr[IDX_W-1:0];
    assign s_tag_in  = snp_addr[ADDR_W-1:IDX_W];
    assign snp_cmd_e = bus_cmd_e'(snp_cmd);
    assign snp_block = sact.hit && (s_idx == c_idx);
    assign snp_abort = sact.supply;
    assign bus_cmd   = cmd_out;
    assign bus_addr  = {bus_tag, c_idx};
    assign bus_src   = MY_ID;

    coh_line_array #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_lines (
        .clk(clk), .rst(rst),
        .s_we(sact.upd), .s_idx(s_idx), .s_state(sact.nxt),
        .c_we(c_we), .c_idx(c_idx), .c_state(c_state), .c_tag(c_tag_in), .c_data(c_data),
        .st_o(st_a), .tag_o(tag_a), .data_o(data_a)
    );

    coh_snoop_unit #(.TAG_W(TAG_W), .DATA_W(DATA_W), .ID_W(ID_W), .MY_ID(MY_ID)) u_snoop (
        .cmd(snp_cmd_e), .src(snp_src), .tag(s_tag_in),
        .lst(st_a[s_idx]), .ltag(tag_a[s_idx]), .ldata(data_a[s_idx]),
        .act(sact), .sdata(snp_wdata)
    );

    coh_req_unit #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_req (
        .cpu_req(cpu_req), .cpu_we(cpu_we), .ctag(c_tag_in), .cwdata(cpu_wdata),
        .lst(st_a[c_idx]), .ltag(tag_a[c_idx]), .ldata(data_a[c_idx]),
        .bus_gnt(bus_gnt), .bus_rdata(bus_rdata), .snp_block(snp_block),
        .cpu_done(cpu_done), .cpu_rdata(cpu_rdata), .bus_req(bus_req),
        .bus_cmd(cmd_out), .bus_tag(bus_tag), .bus_wdata(bus_wdata),
        .c_we(c_we), .c_state(c_state), .c_data(c_data)
    );

    line_state_e cur_st;
    assign cur_st = st_a[c_idx];

    AST_SNOOP_WR_INVAL: assert property (@(posedge clk) disable iff (rst)
        (sact.hit && snp_cmd_e == BC_WRMISS) |=> st_a[$past(s_idx)] == LS_INV); // R6

    AST_SNOOP_RD_SHARE: assert property (@(posedge clk) disable iff (rst)
        (snp_abort && snp_cmd_e == BC_RDMISS) |=> st_a[$past(s_idx)] == LS_SHR); // R7

    AST_WB_CLEARS_LINE: assert property (@(posedge clk) disable iff (rst)
        (bus_cmd == BC_WB) |=> st_a[$past(c_idx)] == LS_INV); // R5

    AST_WRMISS_INSTALL: assert property (@(posedge clk) disable iff (rst)
        (bus_cmd == BC_WRMISS) |=> (st_a[$past(c_idx)] == LS_EXC)
                                   && (data_a[$past(c_idx)] == $past(cpu_wdata))); // R3

    AST_HIT_LOCAL: assert property (@(posedge clk) disable iff (rst)
        (cpu_done && !bus_gnt) |-> !bus_req); // R8

    AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_gnt && !snp_block) |=> st_a[$past(c_idx)] == $past(cur_st)); // R9

endmodule

// File: tb/snoop_msi_cache_test.sv
module snoop_msi_cache_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cpu_req = 1'b0, cpu_we = 1'b0;
    logic [5:0] cpu_addr = '0;
    logic [7:0] cpu_wdata = '0;
    logic       cpu_done;
    logic [7:0] cpu_rdata;
    logic       bus_req;
    logic       bus_gnt = 1'b0;
    logic [1:0] bus_cmd;
    logic [5:0] bus_addr;
    logic [7:0] bus_wdata;
    logic [1:0] bus_src;
    logic [7:0] bus_rdata = '0;
    logic [1:0] snp_cmd = '0;
    logic [5:0] snp_addr = '0;
    logic [1:0] snp_src = '0;
    logic       snp_abort;
    logic [7:0] snp_wdata;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    int         ref_st  [4];
    logic [3:0] ref_tag [4];
    logic [7:0] ref_dat [4];
    logic [7:0] mem     [64];

    always #10 clk = ~clk;

    snoop_msi_cache uut (
        .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_src(bus_src), .bus_rdata(bus_rdata),
        .snp_cmd(snp_cmd), .snp_addr(snp_addr), .snp_src(snp_src),
        .snp_abort(snp_abort), .snp_wdata(snp_wdata)
    );

    task automatic chk_eq(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic idle_cycles(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk); @(negedge clk); #1;
            chk_eq("R12 no command without grant", bus_cmd, 0);
            chk_eq("R9 no completion while waiting", cpu_done, 0);
        end
    endtask

    task automatic access(input bit we, input logic [5:0] a, input logic [7:0] wd, input int dly);
        int i = int'(a[1:0]);
        logic [3:0] t = a[5:2];
        bit valid = (ref_st[i] != 0) && (ref_tag[i] == t);
        bit hit = valid && (!we || ref_st[i] == 2);
        @(negedge clk);
        cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = wd; #1;
        if (hit) begin
            chk_eq("R8 hit completes at once", cpu_done, 1);
            chk_eq("R8 hit raises no bus request", bus_req, 0);
            if (!we) chk_eq("R8 read hit data", cpu_rdata, ref_dat[i]);
            @(posedge clk);
            if (we) ref_dat[i] = wd;
        end else begin
            chk_eq(valid ? "R4 write to shared goes to bus" : "R2 miss raises request", bus_req, 1);
            chk_eq("R4 miss not completed locally", cpu_done, 0);
            if (ref_st[i] == 2) begin
                idle_cycles(dly);
                bus_gnt = 1; #1;
                chk_eq("R5 write-back command", bus_cmd, 3);
                chk_eq("R5 write-back address", bus_addr, {ref_tag[i], i[1:0]});
                chk_eq("R5 write-back data", bus_wdata, ref_dat[i]);
                chk_eq("R5 no completion on write-back", cpu_done, 0);
                mem[{ref_tag[i], i[1:0]}] = ref_dat[i];
                @(posedge clk);
                ref_st[i] = 0;
                @(negedge clk); bus_gnt = 0; #1;
            end
            idle_cycles(dly);
            bus_rdata = mem[a]; bus_gnt = 1; #1;
            chk_eq(we ? (valid ? "R4 upgrade command" : "R3 write miss command") : "R2 read miss command",
                   bus_cmd, we ? 2 : 1);
            chk_eq("R2 miss address", bus_addr, a);
            chk_eq("R2 completes in grant cycle", cpu_done, 1);
            if (!we) chk_eq("R2 fill data returned", cpu_rdata, mem[a]);
            chk_eq("R12 source identity", bus_src, 0);
            @(posedge clk);
            ref_st[i] = we ? 2 : 1; ref_tag[i] = t; ref_dat[i] = we ? wd : mem[a];
        end
        @(negedge clk);
        cpu_req = 0; bus_gnt = 0;
    endtask

    task automatic snoop(input logic [1:0] c, input logic [5:0] a, input logic [1:0] src);
        int i = int'(a[1:0]);
        logic [3:0] t = a[5:2];
        bit hit = (c == 1 || c == 2) && src != 0 && ref_st[i] != 0 && ref_tag[i] == t;
        bit dirty = hit && ref_st[i] == 2;
        @(negedge clk);
        snp_cmd = c; snp_addr = a; snp_src = src; #1;
        chk_eq(!hit ? "R10 ignored snoop no abort" : (c == 2 ? "R6 write snoop abort" : "R7 read snoop abort"),
               snp_abort, dirty);
        if (dirty) begin
            chk_eq(c == 2 ? "R6 supplied data" : "R7 supplied data", snp_wdata, ref_dat[i]);
            mem[a] = ref_dat[i];
        end
        @(posedge clk);
        if (hit) begin
            if (c == 2) ref_st[i] = 0;
            else if (ref_st[i] == 2) ref_st[i] = 1;
        end
        @(negedge clk);
        snp_cmd = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 64; k++) mem[k] = 8'(k * 7 + 3);
        for (int k = 0; k < 4; k++) begin ref_st[k] = 0; ref_tag[k] = '0; ref_dat[k] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;

        // R1: every index misses after reset
        for (int k = 0; k < 4; k++) begin
            cpu_req = 1; cpu_we = 0; cpu_addr = 6'(k); #1;
            chk_eq("R1 reset line misses", bus_req, 1);
            chk_eq("R1 reset line not done", cpu_done, 0);
            chk_eq("R12 idle bus", bus_cmd, 0);
        end
        cpu_req = 0;

        // processor-side sweep over every index with varied grant delays
        for (int k = 0; k < 4; k++) begin
            logic [5:0] a1 = {4'd1, 2'(k)};
            logic [5:0] a2 = {4'd2, 2'(k)};
            access(0, a1, 8'h00, k);
            access(0, a1, 8'h00, 0);
            access(1, a1, 8'hA0 + 8'(k), k);
            access(0, a1, 8'h00, 0);
            access(1, a1, 8'hB0 + 8'(k), 0);
            access(1, a2, 8'hC0 + 8'(k), k);
            access(0, a1, 8'h00, 1);
            snoop(2, a1, 2'd1);
            access(0, a1, 8'h00, 0);
        end

        // snoop sweep on dirty lines
        for (int k = 0; k < 4; k++) begin
            logic [5:0] a3 = {4'd3, 2'(k)};
            access(1, a3, 8'hD0 + 8'(k), 1);
            snoop(3, a3, 2'd1);
            snoop(1, a3, 2'd0);
            snoop(2, a3, 2'd0);
            snoop(1, {4'd9, 2'(k)}, 2'd2);
            access(0, a3, 8'h00, 0);
            snoop((k % 2 == 1) ? 2'd1 : 2'd2, a3, 2'd1);
            access(0, a3, 8'h00, 0);
            snoop(1, a3, 2'd3);
            access(0, a3, 8'h00, 0);
        end

        // R9: shared target invalidated during grant wait still ends as write miss
        access(0, 6'h10, 8'h00, 0);
        @(negedge clk);
        cpu_req = 1; cpu_we = 1; cpu_addr = 6'h10; cpu_wdata = 8'h5A; #1;
        chk_eq("R9 upgrade waits for grant", bus_req, 1);
        @(negedge clk);
        snp_cmd = 2; snp_addr = 6'h10; snp_src = 1; #1;
        chk_eq("R9 clean line no abort", snp_abort, 0);
        @(posedge clk); ref_st[0] = 0;
        @(negedge clk); snp_cmd = 0; bus_rdata = mem[6'h10]; bus_gnt = 1; #1;
        chk_eq("R9 restart as write miss", bus_cmd, 2);
        chk_eq("R9 restart completes", cpu_done, 1);
        @(posedge clk); ref_st[0] = 2; ref_tag[0] = 4'd4; ref_dat[0] = 8'h5A;
        @(negedge clk); cpu_req = 0; bus_gnt = 0;
        access(0, 6'h10, 8'h00, 0);

        // R9: dirty victim cleaned by snoop, no write-back issued
        access(1, 6'h05, 8'h77, 0);
        @(negedge clk);
        cpu_req = 1; cpu_we = 0; cpu_addr = 6'h09; #1;
        chk_eq("R9 victim miss requests", bus_req, 1);
        @(negedge clk);
        snp_cmd = 1; snp_addr = 6'h05; snp_src = 1; #1;
        chk_eq("R7 victim supplied abort", snp_abort, 1);
        chk_eq("R7 victim supplied data", snp_wdata, 8'h77);
        mem[6'h05] = 8'h77;
        @(posedge clk); ref_st[1] = 1;
        @(negedge clk); snp_cmd = 0; bus_rdata = mem[6'h09]; bus_gnt = 1; #1;
        chk_eq("R9 no write-back after clean", bus_cmd, 1);
        chk_eq("R9 read data after clean", cpu_rdata, mem[6'h09]);
        @(posedge clk); ref_st[1] = 1; ref_tag[1] = 4'd2; ref_dat[1] = mem[6'h09];
        @(negedge clk); cpu_req = 0; bus_gnt = 0;

        // R11: snoop on the same index holds a hit for one cycle
        access(0, 6'h02, 8'h00, 0);
        @(negedge clk);
        cpu_req = 1; cpu_we = 0; cpu_addr = 6'h02;
        snp_cmd = 1; snp_addr = 6'h02; snp_src = 2; #1;
        chk_eq("R11 hit held during snoop", cpu_done, 0);
        chk_eq("R11 held hit no bus request", bus_req, 0);
        chk_eq("R7 shared read snoop no abort", snp_abort, 0);
        @(posedge clk); @(negedge clk); snp_cmd = 0; #1;
        chk_eq("R11 hit completes after snoop", cpu_done, 1);
        chk_eq("R11 data after snoop", cpu_rdata, mem[6'h02]);
        @(posedge clk); @(negedge clk); cpu_req = 0;

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule